// File: doc/BRIEF.md
# UART Register Interface

This block is the software-visible face of a simple serial port. A 32-bit register bus reaches it with a byte address. The block decodes the word index from that address and holds three kinds of register: control registers, status registers whose event bits clear when software writes a one to them, and a test register. It drives a single level interrupt. The serializer, deserializer, baud generator and modem pins sit outside the block. The block sees the receive side as a byte (or break) strobe with a can-accept signal, and the transmit side as a byte strobe that it raises itself.

Received characters land in a one-entry holding buffer. This buffer is managed by a two-state machine. In state `RXH_EMPTY` the block advertises that it can accept. The transition `EMPTY->FULL` fires on an accepted strobe and stores the word. In state `RXH_FULL` further strobes are refused. The transition `FULL->EMPTY` fires when software reads the receive data register, and that read is the one that reports the character as valid. A soft-reset transition `ANY->EMPTY` fires when software writes control register 2 with bit 0 at zero. That write reloads the reset values, except for the FIFO-control and one-millisecond scratch registers.

Top module: `uart_regblk`

## Requirements
- R1: After hardware reset the registers read as follows:
  - control 1: 0
  - control 2: 0x0001
  - control 3: 0x0700
  - status 1: 0x6040
  - status 2: 0x4028
  - test: 0x0060
  - modulator: 0
  - baud count: 4
  - FIFO control: 0
  - one-ms: 0
  - receive data: 0x4000

  At the same time `rx_ready` is 1 and `irq` and `tx_valid` are 0.
- R2: A strobe on `rx_valid` while `rx_ready` is 1 stores the byte and drops `rx_ready` on the next cycle. In that state status 1 reads 0x6240 (bit 9 set), status 2 reads 0x4029 (bit 0 set) and test reads 0x0040 (bit 5 clear). A strobe while `rx_ready` is 0 is ignored.
- R3: A read of index 0x00 while a character is held returns the stored word with bit 15 set. It returns to the empty state, so bit 9, bit 0 and `rx_ready` revert and test bit 5 is set again. A read while empty returns the last stored word with bit 15 clear.
- R4: A strobe with `rx_break` high stores the word 0x0800 instead of the byte.
- R5: A write to index 0x10 raises `tx_valid` for one cycle, starting the cycle after the write, with `tx_byte` equal to write data bits 7:0. This happens only if control 2 bit 2 is set. Otherwise nothing is emitted.
- R6: `irq` is a register. One cycle after the inputs change, it equals (status1 bit 9 AND control1 bit 9) OR (status1 bit 13 AND control1 bit 13 AND control1 bit 6).
- R7: A write to index 0x21 with data bit 0 at zero reloads the reset values of control 1, control 3, the status registers, test, modulator, baud count and the receive buffer. Control 2 takes the written value with bit 0 forced to 1. FIFO control and one-ms keep their contents.
- R8: A write to status 1 clears only bits 4, 5, 7, 8, 10, 11, 12 and 15 where the data has ones. A write to status 2 clears only bits 1, 2, 4, 6, 7, 8, 10, 11, 12, 13 and 15. No other status bit changes.
- R9: Writes to control 1 (0x20), control 2 (0x21), control 3 (0x22), FIFO control (0x24), modulator (0x2A) and one-ms (0x2C) keep data bits 15:0. A write to index 0x29 loads the baud count, which is read at 0x2B.
- R10: Reads of indices 0x10, 0x23, 0x29 and any unmapped index return 0. Writes to the test register (0x2D), control 4 (0x23) and unmapped indices change nothing.
- R11: If a read of the empty receive register and an accepted receive strobe fall in the same cycle, the read returns the old word without bit 15 and the new character stays held as valid.
- R12: `bus_rdata` shows the addressed value on the cycle after `bus_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address; word index is bits ADDR_W-1:2 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| rx_valid | input | 1 | Received character strobe |
| rx_byte | input | BYTE_W | Received byte |
| rx_break | input | 1 | Qualifies the strobe as a break event |
| rx_ready | output | 1 | Holding buffer can accept a character |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | BYTE_W | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
Read data, `tx_valid` and the receive state are each one register away from the bus or receive strobe. The bench therefore drives on a falling edge and samples them on the next falling edge, half a cycle after the capturing rising edge. `irq` is one register further on. After any write or strobe that changes it, the bench first checks that `irq` still shows the old level at that same falling edge, then checks the new level one falling edge later.

// File: rtl/uart_regblk_pkg.sv
`timescale 1ns/1ps
package uart_regblk_pkg;

    // Word indices (byte offset >> 2)
    localparam int RI_RXD   = 'h00;
    localparam int RI_TXD   = 'h10;
    localparam int RI_CTL1  = 'h20;
    localparam int RI_CTL2  = 'h21;
    localparam int RI_CTL3  = 'h22;
    localparam int RI_CTL4  = 'h23;
    localparam int RI_FIFO  = 'h24;
    localparam int RI_STAT1 = 'h25;
    localparam int RI_STAT2 = 'h26;
    localparam int RI_BINC  = 'h29;
    localparam int RI_BMOD  = 'h2A;
    localparam int RI_BCNT  = 'h2B;
    localparam int RI_MSEC  = 'h2C;
    localparam int RI_TEST  = 'h2D;

    // Bit positions
    localparam int B_S1_TXRDY  = 13;
    localparam int B_S1_RXRDY  = 9;
    localparam int B_S2_DATRDY = 0;
    localparam int B_C1_TXEIE  = 6;
    localparam int B_C2_TXEN   = 2;
    localparam int B_C2_NRST   = 0;
    localparam int B_TS_RXEMP  = 5;
    localparam int B_RW_VALID  = 15;

    // Reset and constant words (16-bit register view)
    localparam logic [15:0] S1_RST    = 16'h6040;
    localparam logic [15:0] S2_RST    = 16'h4028;
    localparam logic [15:0] TS_FIXED  = 16'h0040;
    localparam logic [15:0] C2_RST    = 16'h0001;
    localparam logic [15:0] C3_RST    = 16'h0700;
    localparam logic [15:0] BCNT_RST  = 16'h0004;
    localparam logic [15:0] RXW_RST   = 16'h4000;
    localparam logic [15:0] RXW_BREAK = 16'h0800;

    // Write-one-to-clear masks
    localparam logic [15:0] S1_W1C = 16'h9DB0;
    localparam logic [15:0] S2_W1C = 16'hBDD6;

    typedef enum logic [0:0] {
        RXH_EMPTY = 1'b0,
        RXH_FULL  = 1'b1
    } rxh_state_e;

endpackage

// File: rtl/uart_rxhold.sv
`timescale 1ns/1ps
module uart_rxhold
    import uart_regblk_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_break,
    input  logic              rd_take,
    output logic              rx_ready,
    output logic              full,
    output logic [REG_W-1:0]  hold_word
);

    localparam int PAD_W = REG_W - BYTE_W;

    rxh_state_e state_q, state_d;
    logic       accept;

    assign accept = rx_valid && (state_q == RXH_EMPTY) && !soft_rst;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RXH_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXH_EMPTY: if (rx_valid) state_d = RXH_FULL;
            RXH_FULL:  if (rd_take)  state_d = RXH_EMPTY;
            default:   state_d = RXH_EMPTY;
        endcase
        if (soft_rst) state_d = RXH_EMPTY;
    end

    // Outputs
    always_comb begin
        rx_ready = 1'b0;
        full     = 1'b0;
        unique case (state_q)
            RXH_EMPTY: rx_ready = 1'b1;
            RXH_FULL:  full     = 1'b1;
            default:   rx_ready = 1'b0;
        endcase
    end

    // Holding word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hold_word <= REG_W'(RXW_RST);
        else if (soft_rst) hold_word <= REG_W'(RXW_RST);
        else if (accept)   hold_word <= rx_break ? REG_W'(RXW_BREAK)
                                                 : {{PAD_W{1'b0}}, rx_byte};
    end

    // R2: an accepted strobe leaves the buffer full
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !soft_rst) |=> !rx_ready);

    // R2: while full the stored word does not move
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !soft_rst) |=> $stable(hold_word));

    // R3: reading a held character empties the buffer
    p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && !rx_ready && !soft_rst) |=> rx_ready);

    // R4: break strobes store the break word
    p_break_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_break && !soft_rst) |=> hold_word == REG_W'(RXW_BREAK));

endmodule

// File: rtl/uart_irqgen.sv
`timescale 1ns/1ps
module uart_irqgen (
    input  logic clk,
    input  logic rst_n,
    input  logic st_rxrdy,
    input  logic st_txrdy,
    input  logic en_rxrdy,
    input  logic en_txrdy,
    input  logic en_txempty,
    output logic irq
);

    logic rx_src, tx_src;

    assign rx_src = st_rxrdy & en_rxrdy;
    assign tx_src = st_txrdy & en_txrdy & en_txempty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= rx_src | tx_src;
    end

endmodule

// File: rtl/uart_regblk.sv
`timescale 1ns/1ps
module uart_regblk
    import uart_regblk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_break,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] wval;
    logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, fifo_q, bmod_q, bcnt_q, msec_q;
    logic [REG_W-1:0] s1_q, s2_q;
    logic [REG_W-1:0] s1_view, s2_view, ts_view, rx_view, hold_word;
    logic [REG_W-1:0] rd_word;
    logic             rx_full, soft_rst, rd_take, tx_fire;
    logic             unused_bits;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign wval        = bus_wdata[REG_W-1:0];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:REG_W]};

    assign soft_rst = bus_wr && (idx == IDX_W'(RI_CTL2)) && !bus_wdata[B_C2_NRST];
    assign rd_take  = bus_rd && (idx == IDX_W'(RI_RXD));
    assign tx_fire  = bus_wr && (idx == IDX_W'(RI_TXD)) && ctl2_q[B_C2_TXEN];

    uart_rxhold #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_rxhold (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rx_break  (rx_break),
        .rd_take   (rd_take),
        .rx_ready  (rx_ready),
        .full      (rx_full),
        .hold_word (hold_word)
    );

    // Status views merge stored bits with receive state
    always_comb begin
        s1_view = s1_q;
        s1_view[B_S1_RXRDY] = rx_full;
        s2_view = s2_q;
        s2_view[B_S2_DATRDY] = rx_full;
        ts_view = REG_W'(TS_FIXED);
        ts_view[B_TS_RXEMP] = !rx_full;
        rx_view = hold_word;
        rx_view[B_RW_VALID] = rx_full;
    end

    uart_irqgen u_irqgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_rxrdy   (s1_view[B_S1_RXRDY]),
        .st_txrdy   (s1_q[B_S1_TXRDY]),
        .en_rxrdy   (ctl1_q[B_S1_RXRDY]),
        .en_txrdy   (ctl1_q[B_S1_TXRDY]),
        .en_txempty (ctl1_q[B_C1_TXEIE]),
        .irq        (irq)
    );

    // Register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl1_q <= '0;
            ctl2_q <= REG_W'(C2_RST);
            ctl3_q <= REG_W'(C3_RST);
            fifo_q <= '0;
            bmod_q <= '0;
            bcnt_q <= REG_W'(BCNT_RST);
            msec_q <= '0;
            s1_q   <= REG_W'(S1_RST);
            s2_q   <= REG_W'(S2_RST);
        end else if (soft_rst) begin
            ctl1_q <= '0;
            ctl2_q <= wval | REG_W'(1);
            ctl3_q <= REG_W'(C3_RST);
            bmod_q <= '0;
            bcnt_q <= REG_W'(BCNT_RST);
            s1_q   <= REG_W'(S1_RST);
            s2_q   <= REG_W'(S2_RST);
        end else if (bus_wr) begin
            case (idx)
                IDX_W'(RI_CTL1):  ctl1_q <= wval;
                IDX_W'(RI_CTL2):  ctl2_q <= wval | REG_W'(1);
                IDX_W'(RI_CTL3):  ctl3_q <= wval;
                IDX_W'(RI_FIFO):  fifo_q <= wval;
                IDX_W'(RI_BINC):  bcnt_q <= wval;
                IDX_W'(RI_BMOD):  bmod_q <= wval;
                IDX_W'(RI_MSEC):  msec_q <= wval;
                IDX_W'(RI_STAT1): s1_q   <= s1_q & ~(wval & REG_W'(S1_W1C));
                IDX_W'(RI_STAT2): s2_q   <= s2_q & ~(wval & REG_W'(S2_W1C));
                default: ;
            endcase
        end
    end

    // Read decode
    always_comb begin
        rd_word = '0;
        case (idx)
            IDX_W'(RI_RXD):   rd_word = rx_view;
            IDX_W'(RI_CTL1):  rd_word = ctl1_q;
            IDX_W'(RI_CTL2):  rd_word = ctl2_q;
            IDX_W'(RI_CTL3):  rd_word = ctl3_q;
            IDX_W'(RI_FIFO):  rd_word = fifo_q;
            IDX_W'(RI_STAT1): rd_word = s1_view;
            IDX_W'(RI_STAT2): rd_word = s2_view;
            IDX_W'(RI_BMOD):  rd_word = bmod_q;
            IDX_W'(RI_BCNT):  rd_word = bcnt_q;
            IDX_W'(RI_MSEC):  rd_word = msec_q;
            IDX_W'(RI_TEST):  rd_word = ts_view;
            default:          rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= DATA_W'(rd_word);
    end

    // Transmit strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= tx_fire;
            if (tx_fire) tx_byte <= bus_wdata[BYTE_W-1:0];
        end
    end

    // R5: a strobe only follows an enabled transmit write
    p_tx_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_wr && idx == IDX_W'(RI_TXD) && ctl2_q[B_C2_TXEN]));

    p_tx_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_W'(RI_TXD) && ctl2_q[B_C2_TXEN]) |=> tx_valid);

    // R6: enabled receive-ready raises the interrupt one cycle later
    p_rx_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && ctl1_q[B_S1_RXRDY]) |=> irq);

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl1_q[B_S1_RXRDY] && !(ctl1_q[B_S1_TXRDY] && ctl1_q[B_C1_TXEIE])) |=> !irq);

    // R7: soft reset clears control 1 and keeps control 2 bit 0 set
    p_soft_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctl1_q == '0 && ctl2_q[B_C2_NRST] && rx_ready));

    // R8: bits outside the clear masks never change
    p_s1_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> $stable(s1_q & ~REG_W'(S1_W1C)));

    p_s2_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> $stable(s2_q & ~REG_W'(S2_W1C)));

endmodule

// File: tb/sim_uart_regblk.sv
`timescale 1ns/1ps
module sim_uart_regblk;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          rx_valid = 1'b0;
    logic [BW-1:0] rx_byte = '0;
    logic          rx_break = 1'b0;
    logic          rx_ready, tx_valid, irq;
    logic [BW-1:0] tx_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_regblk #(.ADDR_W(AW), .DATA_W(DW), .REG_W(16), .BYTE_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(idx << 2); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int idx, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(idx << 2); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(string tag, int idx, logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        chk(tag, v, exp);
    endtask

    task automatic push(logic [7:0] b, bit brk);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_break = brk;
        @(negedge clk);
        rx_valid = 1'b0; rx_break = 1'b0;
    endtask

    function automatic logic [31:0] rx_word(logic [7:0] b, bit brk);
        return brk ? 32'h0800 : {24'h0, b};
    endfunction
    function automatic logic [31:0] s1_exp(bit full);
        return full ? 32'h6240 : 32'h6040;
    endfunction
    function automatic logic [31:0] s2_exp(bit full);
        return full ? 32'h4029 : 32'h4028;
    endfunction
    function automatic logic [31:0] ts_exp(bit full);
        return full ? 32'h0040 : 32'h0060;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] m_c1, m_c3, m_fifo, m_bmod, m_bcnt, m_ms, v, last_w;
        int          sel;
        logic [7:0]  b;
        bit          brk;
        m_c1 = 0; m_c3 = 32'h700; m_fifo = 0; m_bmod = 0; m_bcnt = 4; m_ms = 0;
        v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rx_ready", 32'(rx_ready), 1);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        rd_chk("R1 ctl1", 'h20, 0);
        rd_chk("R1 ctl2", 'h21, 32'h1);
        rd_chk("R1 ctl3", 'h22, 32'h700);
        rd_chk("R1 stat1", 'h25, 32'h6040);
        rd_chk("R1 stat2", 'h26, 32'h4028);
        rd_chk("R1 test", 'h2D, 32'h60);
        rd_chk("R1 bmod", 'h2A, 0);
        rd_chk("R1 bcnt", 'h2B, 4);
        rd_chk("R1 fifo", 'h24, 0);
        rd_chk("R1 msec", 'h2C, 0);
        rd_chk("R1 rxd", 'h00, 32'h4000);

        // R12 read data holds between reads
        rd_chk("R12 first", 'h22, 32'h700);
        repeat (3) @(negedge clk);
        chk("R12 hold", bus_rdata, 32'h700);

        // R9 random store/readback
        for (int i = 0; i < 24; i++) begin
            sel = $urandom_range(0, 5);
            v = $urandom();
            case (sel)
                0: begin wr('h20, v); m_c1 = v & 32'hFFFF; rd_chk("R9 ctl1", 'h20, m_c1); end
                1: begin wr('h22, v); m_c3 = v & 32'hFFFF; rd_chk("R9 ctl3", 'h22, m_c3); end
                2: begin wr('h24, v); m_fifo = v & 32'hFFFF; rd_chk("R9 fifo", 'h24, m_fifo); end
                3: begin wr('h2A, v); m_bmod = v & 32'hFFFF; rd_chk("R9 bmod", 'h2A, m_bmod); end
                4: begin wr('h2C, v); m_ms = v & 32'hFFFF; rd_chk("R9 msec", 'h2C, m_ms); end
                default: begin wr('h29, v); m_bcnt = v & 32'hFFFF; rd_chk("R9 bcnt", 'h2B, m_bcnt); end
            endcase
        end
        wr('h21, 32'hFFFF_0001);
        rd_chk("R9 ctl2", 'h21, 32'h0001);

        // R10 zero reads and ignored writes
        wr('h2D, $urandom());
        wr('h23, $urandom());
        wr('h3F, $urandom());
        rd_chk("R10 test unchanged", 'h2D, 32'h60);
        rd_chk("R10 ctl4", 'h23, 0);
        rd_chk("R10 binc", 'h29, 0);
        rd_chk("R10 txd", 'h10, 0);
        rd_chk("R10 unmapped", 'h3F, 0);
        rd_chk("R10 ctl3 kept", 'h22, m_c3);
        rd_chk("R10 bcnt kept", 'h2B, m_bcnt);

        // R8 status write-one-to-clear
        wr('h25, 32'hFFFF_FFFF);
        rd_chk("R8 stat1", 'h25, 32'h6040);
        wr('h26, 32'hFFFF_FFFF);
        rd_chk("R8 stat2", 'h26, 32'h4028);

        // R5 transmit gating
        wr('h10, 32'hA5);
        chk("R5 disabled", 32'(tx_valid), 0);
        wr('h21, 32'h0005);
        rd_chk("R5 ctl2", 'h21, 32'h5);
        wr('h10, 32'h1C3);
        chk("R5 strobe", 32'(tx_valid), 1);
        chk("R5 byte", 32'(tx_byte), 32'hC3);
        @(negedge clk);
        chk("R5 one cycle", 32'(tx_valid), 0);

        // R2 R3 R4 random receive
        for (int i = 0; i < 16; i++) begin
            b = 8'($urandom());
            brk = ($urandom_range(0, 3) == 0);
            push(b, brk);
            chk("R2 not ready", 32'(rx_ready), 0);
            rd_chk("R2 stat1", 'h25, s1_exp(1));
            rd_chk("R2 stat2", 'h26, s2_exp(1));
            rd_chk("R2 test", 'h2D, ts_exp(1));
            push(~b, 1'b0);
            rd_chk(brk ? "R4 break word" : "R3 valid read", 'h00, 32'h8000 | rx_word(b, brk));
            chk("R3 ready", 32'(rx_ready), 1);
            rd_chk("R3 stat1", 'h25, s1_exp(0));
            rd_chk("R3 test", 'h2D, ts_exp(0));
            rd_chk("R3 reread", 'h00, rx_word(b, brk));
            last_w = rx_word(b, brk);
        end
        push(8'h5A, 1'b1);
        rd_chk("R4 directed break", 'h00, 32'h8800);
        last_w = 32'h0800;

        // R6 interrupt timing
        wr('h20, 0);
        wr('h20, 32'h0200);
        @(negedge clk);
        chk("R6 empty quiet", 32'(irq), 0);
        push(8'h11, 1'b0);
        chk("R6 lag", 32'(irq), 0);
        @(negedge clk);
        chk("R6 rx raise", 32'(irq), 1);
        rd_chk("R6 take", 'h00, 32'h8011);
        chk("R6 still high", 32'(irq), 1);
        @(negedge clk);
        chk("R6 rx drop", 32'(irq), 0);
        last_w = 32'h11;
        wr('h20, 32'h2000);
        @(negedge clk);
        chk("R6 tx masked", 32'(irq), 0);
        wr('h20, 32'h2040);
        chk("R6 tx lag", 32'(irq), 0);
        @(negedge clk);
        chk("R6 tx raise", 32'(irq), 1);
        wr('h20, 32'h0040);
        @(negedge clk);
        chk("R6 tx drop", 32'(irq), 0);

        // R11 same-cycle read and receive while empty
        @(negedge clk);
        bus_addr = '0; bus_rd = 1'b1; rx_valid = 1'b1; rx_byte = 8'h3C; rx_break = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0; rx_valid = 1'b0;
        chk("R11 old word", bus_rdata, last_w);
        chk("R11 held", 32'(rx_ready), 0);
        rd_chk("R11 valid", 'h00, 32'h803C);

        // R7 soft reset
        wr('h20, 32'h2240);
        wr('h22, 32'h1234);
        wr('h2A, 32'h55);
        wr('h29, 32'h99);
        wr('h24, 32'h0801);
        wr('h2C, 32'h03E8);
        push(8'h66, 1'b0);
        wr('h21, 32'h0004);
        chk("R7 ready", 32'(rx_ready), 1);
        rd_chk("R7 ctl2", 'h21, 32'h5);
        rd_chk("R7 ctl1", 'h20, 0);
        rd_chk("R7 ctl3", 'h22, 32'h700);
        rd_chk("R7 bmod", 'h2A, 0);
        rd_chk("R7 bcnt", 'h2B, 4);
        rd_chk("R7 rxd", 'h00, 32'h4000);
        rd_chk("R7 stat1", 'h25, 32'h6040);
        rd_chk("R7 test", 'h2D, 32'h60);
        rd_chk("R7 fifo kept", 'h24, 32'h0801);
        rd_chk("R7 msec kept", 'h2C, 32'h03E8);
        chk("R7 irq", 32'(irq), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule